// File: doc/BRIEF.md
# Flag-Producing ALU with Compare Outputs

This is a purely combinational arithmetic-logic unit for a datapath of configurable width. It takes two operands and a three-bit function code. It returns one result word, chosen from a bitwise AND, a bitwise OR or a sum. The top bit of the function code complements the second operand before it reaches any of the three paths. In the arithmetic path that same bit also forces a carry-in of one, so the sum becomes a difference. Two function codes have no operation and return zero.

The four status flags are negative, carry, zero and signed overflow. They always describe an internal subtraction of the second operand from the first, whichever function is selected. The unsigned and signed greater-or-equal outputs are derived from those flags, so no separate magnitude comparator is needed. A consumer can therefore branch on a comparison in the same cycle that it uses a logic or add result from the same operands.

Top module: `cmpAlu`

## Requirements
- R1: Function code 3'b000 gives opA & opB, and 3'b001 gives opA | opB.
- R2: Function code 3'b100 gives opA & ~opB, and 3'b101 gives opA | ~opB.
- R3: Function code 3'b010 gives (opA + opB) mod 2^WIDTH, and 3'b110 gives (opA - opB) mod 2^WIDTH.
- R4: Function codes 3'b011 and 3'b111 give a result of all zeros.
- R5: flagNeg equals bit WIDTH-1 of (opA - opB) mod 2^WIDTH. flagZero is 1 exactly when opA equals opB.
- R6: flagCarry is the carry-out of opA + ~opB + 1. It is 1 exactly when opA >= opB as unsigned numbers, and this includes every case with opB = 0.
- R7: flagOvf is 1 exactly when the true signed difference opA - opB, with both operands read as two's complement, lies outside the WIDTH-bit signed range.
- R8: geUnsigned equals flagCarry. It is 1 exactly when opA >= opB as unsigned numbers.
- R9: geSigned is 1 exactly when flagOvf equals flagNeg. It is 1 exactly when opA >= opB as signed numbers.
- R10: The four flags and both compare outputs do not depend on funcSel. The same operands give the same values under all eight function codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand, complemented when funcSel[2] is 1 |
| funcSel | input | 3 | Function code |
| result | output | WIDTH | Selected result word |
| flagNeg | output | 1 | Sign bit of opA - opB |
| flagCarry | output | 1 | Carry-out of opA - opB |
| flagZero | output | 1 | opA - opB is zero |
| flagOvf | output | 1 | Signed overflow of opA - opB |
| geUnsigned | output | 1 | opA >= opB, unsigned |
| geSigned | output | 1 | opA >= opB, signed |

## Verification
The bench drives operands at the signed and unsigned extremes, for example the most negative value against one, the most positive value against -1, and zero against zero. These are the points where an overflow term with the wrong polarity breaks signed compare, or where a missing carry-in makes a difference off by one. Equal operands, and a zero subtrahend, check that the carry reads as "no borrow" and not as a raw adder overflow. Each operand pair is replayed under all eight function codes. A design that let the function code leak into the flags, or that passed the sum through for an unused code, would then show a changed flag or a nonzero result.

// File: rtl/cmpAluPkg.sv
package cmpAluPkg;

  typedef enum logic [1:0] {
    PICK_AND  = 2'b00,
    PICK_OR   = 2'b01,
    PICK_SUM  = 2'b10,
    PICK_ZERO = 2'b11
  } resultPick_e;

  typedef struct packed {
    logic        invertB;
    logic        carryIn;
    resultPick_e pick;
  } aluStrobes_t;

endpackage

// File: rtl/aluControl.sv
module aluControl
  import cmpAluPkg::*;
(
  input  logic [2:0]  funcSel,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes.invertB = funcSel[2];
    strobes.carryIn = funcSel[2];
    unique case (funcSel[1:0])
      2'b00:   strobes.pick = PICK_AND;
      2'b01:   strobes.pick = PICK_OR;
      2'b10:   strobes.pick = PICK_SUM;
      default: strobes.pick = PICK_ZERO;
    endcase
  end

endmodule

// File: rtl/aluAdder.sv
module aluAdder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wide;

  always_comb begin
    wide = {1'b0, addA} + {1'b0, addB} + {{WIDTH{1'b0}}, cin};
    sum  = wide[MSB:0];
    cout = wide[WIDTH];
    // overflow: adder inputs agree in sign, sum sign disagrees
    ovf  = (addA[MSB] ~^ addB[MSB]) & (sum[MSB] ^ addA[MSB]);
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import cmpAluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             flagNeg,
  output logic             flagCarry,
  output logic             flagZero,
  output logic             flagOvf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] opBSel;
  logic [WIDTH-1:0] sumWord;
  logic             sumCout;
  logic             sumOvf;
  logic [WIDTH-1:0] diffWord;
  logic             diffCout;
  logic             diffOvf;

  assign opBSel = strobes.invertB ? ~opB : opB;

  // result path: sum or difference, steered by control strobes
  aluAdder #(.WIDTH(WIDTH)) uResAdd (
    .addA(opA), .addB(opBSel), .cin(strobes.carryIn),
    .sum(sumWord), .cout(sumCout), .ovf(sumOvf)
  );

  // flag path: always opA - opB
  aluAdder #(.WIDTH(WIDTH)) uCmpAdd (
    .addA(opA), .addB(~opB), .cin(1'b1),
    .sum(diffWord), .cout(diffCout), .ovf(diffOvf)
  );

  always_comb begin
    unique case (strobes.pick)
      PICK_AND: result = opA & opBSel;
      PICK_OR:  result = opA | opBSel;
      PICK_SUM: result = sumWord;
      default:  result = '0;
    endcase
  end

  assign flagNeg   = diffWord[MSB];
  assign flagZero  = ~|diffWord;
  assign flagCarry = diffCout;
  assign flagOvf   = diffOvf;

  // the subtract result lane and the flag lane must agree when both compute opA - opB
  always_comb begin
    if (!$isunknown({opA, opB, strobes})) begin
      if (strobes.pick == PICK_SUM && strobes.invertB) begin
        p_sub_lanes_agree_r3: assert (sumWord == diffWord && sumCout == diffCout
                                      && sumOvf == diffOvf)
          else $error("R3: result adder and flag adder disagree on opA-opB");
      end
      if (strobes.pick == PICK_SUM && !strobes.invertB) begin
        p_add_r3: assert (result == opA + opB)
          else $error("R3: add result wrong");
      end
    end
  end

endmodule

// File: rtl/cmpAlu.sv
module cmpAlu
  import cmpAluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       funcSel,
  output logic [WIDTH-1:0] result,
  output logic             flagNeg,
  output logic             flagCarry,
  output logic             flagZero,
  output logic             flagOvf,
  output logic             geUnsigned,
  output logic             geSigned
);

  aluStrobes_t strobes;

  aluControl uCtrl (
    .funcSel(funcSel),
    .strobes(strobes)
  );

  aluDatapath #(.WIDTH(WIDTH)) uPath (
    .opA(opA), .opB(opB), .strobes(strobes),
    .result(result),
    .flagNeg(flagNeg), .flagCarry(flagCarry),
    .flagZero(flagZero), .flagOvf(flagOvf)
  );

  assign geUnsigned = flagCarry;
  assign geSigned   = ~(flagNeg ^ flagOvf);

  always_comb begin
    if (!$isunknown({opA, opB, funcSel})) begin
      p_unused_zero_r4: assert (funcSel[1:0] != 2'b11 || result == '0)
        else $error("R4: unused code gave nonzero result");
      p_zero_eq_r5: assert (flagZero == (opA == opB))
        else $error("R5: zero flag disagrees with equality");
      p_ge_unsigned_r8: assert (geUnsigned == (opA >= opB))
        else $error("R8: unsigned compare wrong");
      p_ge_signed_r9: assert (geSigned == ($signed(opA) >= $signed(opB)))
        else $error("R9: signed compare wrong");
      p_and_r1: assert (funcSel != 3'b000 || result == (opA & opB))
        else $error("R1: and result wrong");
    end
  end

endmodule

// File: tb/sim_cmpAlu.sv
module sim_cmpAlu;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] opA, opB;
  logic [2:0]   funcSel;
  logic [W-1:0] result;
  logic flagNeg, flagCarry, flagZero, flagOvf, geUnsigned, geSigned;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpAlu #(.WIDTH(W)) u0 (
    .opA(opA), .opB(opB), .funcSel(funcSel), .result(result),
    .flagNeg(flagNeg), .flagCarry(flagCarry), .flagZero(flagZero),
    .flagOvf(flagOvf), .geUnsigned(geUnsigned), .geSigned(geSigned)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h (opA=%h opB=%h func=%b)",
               tag, got, exp, opA, opB, funcSel);
    end
  endtask

  function automatic logic [W-1:0] expResult(input logic [2:0] f, input logic [W-1:0] a,
                                              input logic [W-1:0] b);
    case (f)
      3'b000: return a & b;
      3'b001: return a | b;
      3'b010: return a + b;
      3'b100: return a & ~b;
      3'b101: return a | ~b;
      3'b110: return a - b;
      default: return '0;
    endcase
  endfunction

  function automatic logic expOvf(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa, sb, d;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    d  = sa - sb;
    return (d > 64'sd2147483647) || (d < -64'sd2147483648);
  endfunction

  task automatic runVector(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] d;
    d = a - b;
    for (int f = 0; f < 8; f++) begin
      @(posedge clk);
      opA = a; opB = b; funcSel = 3'(f);
      @(negedge clk);
      case (f)
        0, 1: check("R1 result", 64'(result), 64'(expResult(3'(f), a, b)));
        4, 5: check("R2 result", 64'(result), 64'(expResult(3'(f), a, b)));
        2, 6: check("R3 result", 64'(result), 64'(expResult(3'(f), a, b)));
        default: check("R4 result", 64'(result), 64'(0));
      endcase
      check("R5 neg",  64'(flagNeg),  64'(d[W-1]));
      check("R5 zero", 64'(flagZero), 64'(a == b));
      check("R6 carry", 64'(flagCarry), 64'(a >= b));
      check("R7 ovf", 64'(flagOvf), 64'(expOvf(a, b)));
      check("R8 geu", 64'(geUnsigned), 64'(a >= b));
      check("R9 ges", 64'(geSigned), 64'($signed(a) >= $signed(b)));
      // R10: flags identical under every function code (checked against operand-only model above)
      check("R10 flags", 64'({flagNeg, flagCarry, flagZero, flagOvf}),
            64'({d[W-1], a >= b, a == b, expOvf(a, b)}));
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    opA = '0; opB = '0; funcSel = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle state with zero operands
    check("R1 reset result", 64'(result), 64'(0));
    check("R5 reset zero", 64'(flagZero), 64'(1));
    check("R6 reset carry", 64'(flagCarry), 64'(1));
    check("R9 reset ges", 64'(geSigned), 64'(1));
    rst = 1'b0;

    // directed corners
    runVector(32'h0000_0000, 32'h0000_0000);
    runVector(32'h8000_0000, 32'h0000_0001);
    runVector(32'h7FFF_FFFF, 32'hFFFF_FFFF);
    runVector(32'h0000_0005, 32'h0000_0000);
    runVector(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    runVector(32'h0000_0000, 32'hFFFF_FFFF);
    runVector(32'h8000_0000, 32'h7FFF_FFFF);
    runVector(32'h7FFF_FFFF, 32'h8000_0000);
    runVector(32'h1234_5678, 32'h1234_5679);
    runVector(32'hFFFF_FFFF, 32'h0000_0001);

    // random operands, with occasional equal or edge-biased picks
    for (int i = 0; i < 1500; i++) begin
      logic [W-1:0] a, b;
      a = $urandom();
      b = $urandom();
      case ($urandom_range(0, 7))
        0: b = a;
        1: a = 32'h8000_0000 ^ ($urandom_range(0, 3));
        2: b = 32'h7FFF_FFFF - ($urandom_range(0, 3));
        3: b = 32'h0;
        default: ;
      endcase
      runVector(a, b);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule